// File: doc/BRIEF.md
# Memory Interface with Split Instruction Register

This block sits between the ALU and an 8-bit memory in a small byte-wide datapath. It holds an address register, a data register and a 16-bit instruction register. The address register and the data register drive the memory address and write-data pins at all times. The data register loads either from the ALU result or from memory read data. The instruction register fills one byte per memory read: the upper byte is read first, and the lower byte is read from the following address.

A four-way result selector returns a byte to the register set. The choices are the ALU result, the data register, a literal held in the low byte of the instruction, or zero.

The `mem_busy` input is high while memory is still completing an access. Loads from memory happen only on cycles where `mem_busy` is low. Loads from the ALU do not depend on `mem_busy`. The read and write strobes and the wait sequencing belong to a separate sequencer.

Top module: `memif_split_ir`

## Requirements
- R1: When `rst` is high at a rising clock edge, the address register, the data register and the instruction register all clear to zero. `mem_addr`, `mem_wdata` and `ir_word` then read 0.
- R2: When `mar_load` is 1 at an edge, `mem_addr` takes `alu_y`. When `mar_load` is 0, `mem_addr` holds its value.
- R3: When `mdr_mode` is 1 (2'b01) at an edge, `mem_wdata` takes `alu_y`, whatever the value of `mem_busy`.
- R4: When `mdr_mode` is 2 (2'b10) at an edge and `mem_busy` is low, `mem_wdata` takes `mem_rdata`. When `mem_busy` is high, `mem_wdata` holds.
- R5: When `mdr_mode` is 0 or 3, `mem_wdata` holds.
- R6: When `ir_hi_load` is 1 and `mem_busy` is low at an edge, `ir_word[15:8]` takes `mem_rdata`. `ir_word[7:0]` is unchanged unless `ir_lo_load` is also set.
- R7: When `ir_lo_load` is 1 and `mem_busy` is low at an edge, `ir_word[7:0]` takes `mem_rdata`. `ir_word[15:8]` is unchanged unless `ir_hi_load` is also set.
- R8: While `mem_busy` is high, neither IR load changes `ir_word`.
- R9: `result` is a combinational function of `res_sel`:
  - 0 gives `alu_y`;
  - 1 gives the data register (equal to `mem_wdata`);
  - 2 gives 8'h00;
  - 3 gives `ir_word[7:0]`.
- R10: Two reads give a complete instruction word. A read with `ir_hi_load` at address A, followed by a read with `ir_lo_load` at address A+1, leaves `ir_word` equal to {byte at A, byte at A+1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mar_load | input | 1 | Load address register from ALU |
| mdr_mode | input | 2 | 0/3 hold, 1 load ALU, 2 load memory data |
| ir_hi_load | input | 1 | Load IR upper byte from memory data |
| ir_lo_load | input | 1 | Load IR lower byte from memory data |
| res_sel | input | 2 | Result selector (see R9) |
| mem_busy | input | 1 | Memory access not complete; read data invalid |
| alu_y | input | DATA_W | ALU result |
| mem_rdata | input | DATA_W | Memory read data |
| mem_addr | output | DATA_W | Address register contents |
| mem_wdata | output | DATA_W | Data register contents |
| ir_word | output | 2*DATA_W | Instruction register |
| result | output | DATA_W | Value returned to the register set |

## Verification
The bound checker tests the register-update rules on every cycle:
- reset clearing;
- address and data register loads and holds;
- the gating of each IR half by `mem_busy`.

The result selector is combinational and has no state to compare against over time, so only the bench's samples cover it. The bench also covers the two-read instruction assembly with wait cycles inserted, and the case where both IR halves load in the same cycle.

// File: rtl/memif_split_ir.sv
module memif_split_ir #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mar_load,
  input  logic [1:0]            mdr_mode,
  input  logic                  ir_hi_load,
  input  logic                  ir_lo_load,
  input  logic [1:0]            res_sel,
  input  logic                  mem_busy,
  input  logic [DATA_W-1:0]     alu_y,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [DATA_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [2*DATA_W-1:0]   ir_word,
  output logic [DATA_W-1:0]     result
);
  localparam logic [1:0] MDR_ALU = 2'd1;
  localparam logic [1:0] MDR_MEM = 2'd2;

  logic [DATA_W-1:0] mar_q, mdr_q, ir_hi_q, ir_lo_q;
  logic              rd_ok;

  assign rd_ok = !mem_busy;

  always_ff @(posedge clk) begin
    if (rst)           mar_q <= '0;
    else if (mar_load) mar_q <= alu_y;
  end

  always_ff @(posedge clk) begin
    if (rst)                                mdr_q <= '0;
    else if (mdr_mode == MDR_ALU)           mdr_q <= alu_y;
    else if (mdr_mode == MDR_MEM && rd_ok)  mdr_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_hi_q <= '0;
      ir_lo_q <= '0;
    end else if (rd_ok) begin
      if (ir_hi_load) ir_hi_q <= mem_rdata;
      if (ir_lo_load) ir_lo_q <= mem_rdata;
    end
  end

  always_comb begin
    unique case (res_sel)
      2'd0:    result = alu_y;
      2'd1:    result = mdr_q;
      2'd2:    result = '0;
      default: result = ir_lo_q;
    endcase
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign ir_word   = {ir_hi_q, ir_lo_q};
endmodule

module memif_split_ir_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                mar_load,
  input logic [1:0]          mdr_mode,
  input logic                ir_hi_load,
  input logic                ir_lo_load,
  input logic                mem_busy,
  input logic [DATA_W-1:0]   alu_y,
  input logic [DATA_W-1:0]   mem_rdata,
  input logic [DATA_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [2*DATA_W-1:0] ir_word
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && mem_wdata == '0 && ir_word == '0)); // R1
  AST_MAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    mar_load |=> mem_addr == $past(alu_y)); // R2
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mar_load |=> $stable(mem_addr)); // R2
  AST_MDR_ALU: assert property (@(posedge clk) disable iff (rst)
    mdr_mode == 2'd1 |=> mem_wdata == $past(alu_y)); // R3
  AST_MDR_MEM: assert property (@(posedge clk) disable iff (rst)
    (mdr_mode == 2'd2 && !mem_busy) |=> mem_wdata == $past(mem_rdata)); // R4
  AST_MDR_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mdr_mode == 2'd2 && mem_busy) |=> $stable(mem_wdata)); // R4
  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mdr_mode == 2'd0 || mdr_mode == 2'd3) |=> $stable(mem_wdata)); // R5
  AST_IR_HI: assert property (@(posedge clk) disable iff (rst)
    (ir_hi_load && !mem_busy) |=> ir_word[2*DATA_W-1:DATA_W] == $past(mem_rdata)); // R6
  AST_IR_HI_KEEP_LO: assert property (@(posedge clk) disable iff (rst)
    !ir_lo_load |=> $stable(ir_word[DATA_W-1:0])); // R6
  AST_IR_LO: assert property (@(posedge clk) disable iff (rst)
    (ir_lo_load && !mem_busy) |=> ir_word[DATA_W-1:0] == $past(mem_rdata)); // R7
  AST_IR_LO_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
    !ir_hi_load |=> $stable(ir_word[2*DATA_W-1:DATA_W])); // R7
  AST_IR_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_busy |=> $stable(ir_word)); // R8
endmodule

bind memif_split_ir memif_split_ir_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mar_load(mar_load), .mdr_mode(mdr_mode),
  .ir_hi_load(ir_hi_load), .ir_lo_load(ir_lo_load), .mem_busy(mem_busy),
  .alu_y(alu_y), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ir_word(ir_word)
);

// File: tb/memif_split_ir_tb.sv
module memif_split_ir_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mar_load = 1'b0;
  logic [1:0]  mdr_mode = 2'd0;
  logic        ir_hi_load = 1'b0, ir_lo_load = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        mem_busy = 1'b0;
  logic [7:0]  alu_y = 8'h00, mem_rdata = 8'h00;
  logic [7:0]  mem_addr, mem_wdata, result;
  logic [15:0] ir_word;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  m_mar = 8'h00, m_mdr = 8'h00;
  logic [15:0] m_ir = 16'h0000;
  logic [7:0]  mem [256];

  always #10 clk = ~clk;

  memif_split_ir u_dut (
    .clk(clk), .rst(rst), .mar_load(mar_load), .mdr_mode(mdr_mode),
    .ir_hi_load(ir_hi_load), .ir_lo_load(ir_lo_load), .res_sel(res_sel),
    .mem_busy(mem_busy), .alu_y(alu_y), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ir_word(ir_word),
    .result(result)
  );

  function automatic logic [7:0] exp_result(input logic [1:0] s, input logic [7:0] a,
                                            input logic [7:0] d, input logic [15:0] ir);
    case (s)
      2'd0: return a;
      2'd1: return d;
      2'd2: return 8'h00;
      default: return ir[7:0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic ml, input logic [1:0] mm, input logic hi,
                       input logic lo, input logic [1:0] rs, input logic bz,
                       input logic [7:0] a, input logic [7:0] rd);
    rst = r; mar_load = ml; mdr_mode = mm; ir_hi_load = hi; ir_lo_load = lo;
    res_sel = rs; mem_busy = bz; alu_y = a; mem_rdata = rd;
    #2;
    chk("R9 result", {8'h00, result}, {8'h00, exp_result(rs, a, m_mdr, m_ir)});
    @(posedge clk);
    if (r) begin
      m_mar = 0; m_mdr = 0; m_ir = 0;
    end else begin
      if (ml) m_mar = a;
      if (mm == 2'd1) m_mdr = a;
      else if (mm == 2'd2 && !bz) m_mdr = rd;
      if (!bz && hi) m_ir[15:8] = rd;
      if (!bz && lo) m_ir[7:0] = rd;
    end
    @(negedge clk);
    chk(r ? "R1 mem_addr" : "R2 mem_addr", {8'h00, mem_addr}, {8'h00, m_mar});
    chk(r ? "R1 mem_wdata" : (mm == 2'd1) ? "R3 mem_wdata" : (mm == 2'd2) ? "R4 mem_wdata"
          : "R5 mem_wdata", {8'h00, mem_wdata}, {8'h00, m_mdr});
    chk(r ? "R1 ir_word" : bz ? "R8 ir_word" : (hi ? "R6 ir_word" : "R7 ir_word"),
        ir_word, m_ir);
  endtask

  task automatic fetch(input logic [7:0] pc, input int waits);
    apply(0, 1, 2'd0, 0, 0, 2'd0, 0, pc, 8'h00);
    for (int k = 0; k < waits; k++) apply(0, 0, 2'd0, 1, 0, 2'd3, 1, 8'h00, 8'hEE);
    apply(0, 0, 2'd0, 1, 0, 2'd3, 0, 8'h00, mem[mem_addr]);
    apply(0, 1, 2'd0, 0, 0, 2'd0, 0, pc + 8'd1, 8'h00);
    for (int k = 0; k < waits; k++) apply(0, 0, 2'd0, 0, 1, 2'd3, 1, 8'h00, 8'h77);
    apply(0, 0, 2'd0, 0, 1, 2'd3, 0, 8'h00, mem[mem_addr]);
    chk("R10 fetched word", ir_word, {mem[pc], mem[pc + 8'd1]});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    @(negedge clk);
    apply(1, 0, 2'd0, 0, 0, 2'd2, 0, 8'h5A, 8'hA5);
    chk("R1 reset ir", ir_word, 16'h0000);
    chk("R9 zero select", {8'h00, result}, 16'h0000);
    fetch(8'd20, 0);
    fetch(8'd22, 3);
    chk("R9 literal", {8'h00, result}, {8'h00, mem[23]});
    apply(0, 0, 2'd1, 0, 0, 2'd1, 1, 8'hC3, 8'h00);
    chk("R3 alu load under busy", {8'h00, mem_wdata}, 16'h00C3);
    apply(0, 0, 2'd2, 0, 0, 2'd1, 1, 8'h00, 8'h3C);
    chk("R4 busy hold", {8'h00, mem_wdata}, 16'h00C3);
    apply(0, 0, 2'd3, 0, 0, 2'd1, 0, 8'h99, 8'h66);
    chk("R5 mode3 hold", {8'h00, mem_wdata}, 16'h00C3);
    apply(0, 0, 2'd2, 1, 1, 2'd1, 0, 8'h00, 8'h81);
    chk("R6 R7 both halves", ir_word, 16'h8181);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      apply(r[31:26] == 6'd0, r[0], r[2:1], r[3], r[4], r[6:5], r[7] & r[8],
            r[16:9], r[24:17]);
    end
    apply(1, 1, 2'd1, 1, 1, 2'd0, 0, 8'hFF, 8'hFF);
    chk("R1 late reset", ir_word, 16'h0000);
    finish_run();
  end
endmodule